// File: doc/BRIEF.md
# Card-Slot Status and Interrupt Block

This block is a small register-mapped control unit for a board with a removable memory card slot. It answers on a 32-bit, word-addressed register bus. It returns a fixed identification word, a fixed address-decode word and an always-zero programming word. It also holds one live status register that reports the state of the card slot.

Two level inputs come from the card interface: write-protect and card-present. Both are brought into the clock domain through multi-flop synchronisers. The write-protect level is shown live in the status register. A new card insertion, seen as a rising edge of the synchronised card-present level, sets a sticky flag. That flag drives the interrupt output until software acknowledges it by writing a one to the flag's bit.

Top module: `card_slot_ctrl`

## Requirements
- R1: A read of word 0 returns 0x41034003, a read of word 3 returns 0x00000011 and a read of word 1 returns zero. Read data is registered: it changes on the clock edge that samples `bus_rd` and holds until the next read.
- R2: Writes to words 0, 1 and 3 change neither the read-back values nor the interrupt output.
- R3: Bit 0 of word 2 equals the write-protect input after a two-flop synchroniser. Writes do not change it. Word 2 bits other than 0 and 3 read as zero.
- R4: A rising edge of the synchronised card-present level sets bit 3 of word 2. The bit stays set after the input drops.
- R5: Writing word 2 with bit 3 set clears the sticky card bit. A write to word 2 with bit 3 clear has no effect, whatever its other bits hold.
- R6: `card_irq` equals the sticky card bit. It rises on the edge after a card rising edge is detected and falls on the edge that takes the clearing write.
- R7: If a card rising edge and a clearing write arrive in the same cycle, the bit ends up set.
- R8: A card-present level that stays high does not set the bit again after a clear. A new rising edge is needed.
- R9: Reads of words 4 and above return zero. Writes to them are ignored, including words whose low two address bits match a mapped word.
- R10: After reset the sticky bit, `card_irq` and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| wp_in | input | 1 | Card write-protect level, asynchronous |
| card_in | input | 1 | Card-present level, asynchronous |
| card_irq | output | 1 | Card insertion interrupt, held until acknowledged |

## Verification
The hardest case to reach is a clearing write that lands in exactly the cycle in which the synchroniser chain reports a new card edge. Only then does the set-over-clear priority decide the result. The bench raises `card_in` at a known falling edge and counts two rising edges through the synchroniser. It then presents the clearing write so that the third edge samples the write and the edge pulse together. Holding the card level high across a clear, then dropping and raising it again, separates edge detection from level detection.

// File: rtl/card_slot_pkg.sv
`timescale 1ns/1ps
package card_slot_pkg;
   // word indices inside the mapped window
   localparam logic [1:0] IDX_ID     = 2'd0;
   localparam logic [1:0] IDX_PROG   = 2'd1;
   localparam logic [1:0] IDX_STAT   = 2'd2;
   localparam logic [1:0] IDX_DECODE = 2'd3;
   localparam int         NUM_WORDS  = 4;
   // status word bit positions
   localparam int         BIT_WP     = 0;
   localparam int         BIT_CARD   = 3;
endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cs_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cs_event_latch.sv
`timescale 1ns/1ps
module cs_event_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic clear,
   output logic rise,
   output logic flag
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= level;
   end

   assign rise = level & ~prev;

   // a fresh edge takes priority over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (rise)  flag <= 1'b1;
      else if (clear) flag <= 1'b0;
   end
endmodule

// File: rtl/cs_regfile.sv
`timescale 1ns/1ps
module cs_regfile
   import card_slot_pkg::*;
#(
   parameter int                ADDR_W       = 6,
   parameter int                DATA_W       = 32,
   parameter logic [DATA_W-1:0] ID_VALUE     = '0,
   parameter logic [DATA_W-1:0] DECODE_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              wp_level,
   input  logic              card_flag,
   output logic              card_clear,
   output logic [DATA_W-1:0] bus_rdata
);
   logic              hit;
   logic [1:0]        widx;
   logic [DATA_W-1:0] rd_next;
   logic              wdata_unused;

   assign hit  = (bus_addr < ADDR_W'(NUM_WORDS));
   assign widx = bus_addr[1:0];

   assign card_clear = bus_wr && hit && (widx == IDX_STAT) && bus_wdata[BIT_CARD];
   assign wdata_unused = ^{bus_wdata[DATA_W-1:BIT_CARD+1], bus_wdata[BIT_CARD-1:0]};

   always_comb begin
      rd_next = '0;
      if (hit) begin
         unique case (widx)
            IDX_ID:     rd_next = ID_VALUE;
            IDX_PROG:   rd_next = '0;
            IDX_STAT: begin
               rd_next[BIT_WP]   = wp_level;
               rd_next[BIT_CARD] = card_flag;
            end
            IDX_DECODE: rd_next = DECODE_VALUE;
            default:    rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/card_slot_ctrl.sv
`timescale 1ns/1ps
module card_slot_ctrl
   import card_slot_pkg::*;
#(
   parameter int                ADDR_W       = 6,
   parameter int                DATA_W       = 32,
   parameter int                SYNC_STAGES  = 2,
   parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
   parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wp_in,
   input  logic              card_in,
   output logic              card_irq
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("card_slot_ctrl: ADDR_W must cover the four mapped words");
   end
   if (DATA_W <= BIT_CARD) begin : g_bad_data
      $error("card_slot_ctrl: DATA_W too narrow for the status bits");
   end

   logic [1:0] pins_sync;
   logic       wp_level;
   logic       card_level;
   logic       card_rise;
   logic       card_flag;
   logic       card_clear;

   cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({card_in, wp_in}),
      .q     (pins_sync)
   );

   assign wp_level   = pins_sync[0];
   assign card_level = pins_sync[1];

   cs_event_latch u_card (
      .clk   (clk),
      .rst_n (rst_n),
      .level (card_level),
      .clear (card_clear),
      .rise  (card_rise),
      .flag  (card_flag)
   );

   cs_regfile #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .ID_VALUE     (ID_VALUE),
      .DECODE_VALUE (DECODE_VALUE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .wp_level   (wp_level),
      .card_flag  (card_flag),
      .card_clear (card_clear),
      .bus_rdata  (bus_rdata)
   );

   assign card_irq = card_flag;
endmodule

// File: rtl/card_slot_ctrl_chk.sv
`timescale 1ns/1ps
module card_slot_ctrl_chk #(
   parameter int                ADDR_W   = 6,
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              card_irq,
   input logic              card_rise
);
   logic ack_wr;
   assign ack_wr = bus_wr && (bus_addr == ADDR_W'(2)) && bus_wdata[3];

   assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(0)) |=> (bus_rdata == ID_VALUE));

   assert_hold_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (card_irq && !ack_wr) |=> card_irq);

   assert_fall_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_irq) |-> $past(ack_wr));

   assert_rise_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_irq) |-> $past(card_rise));

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      card_rise |=> card_irq);

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr >= ADDR_W'(4)) |=> (bus_rdata == '0));
endmodule

bind card_slot_ctrl card_slot_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .ID_VALUE (ID_VALUE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .card_irq  (card_irq),
   .card_rise (card_rise)
);

// File: tb/tb_card_slot_ctrl.sv
`timescale 1ns/1ps
module tb_card_slot_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wp_in = 1'b0;
   logic        card_in = 1'b0;
   logic        card_irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   card_slot_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wp_in     (wp_in),
      .card_in   (card_in),
      .card_irq  (card_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      chk("R10 irq after reset", {31'b0, card_irq}, 32'h0);
      chk("R10 rdata after reset", bus_rdata, 32'h0);
      bus_read(6'd2, rv);
      chk("R10 status after reset", rv, 32'h0);
   endtask

   task automatic t_constants;
      bus_read(6'd0, rv); chk("R1 id word", rv, 32'h4103_4003);
      bus_read(6'd3, rv); chk("R1 decode word", rv, 32'h0000_0011);
      bus_read(6'd1, rv); chk("R1 prog word", rv, 32'h0);
      wait_cyc(2);
      chk("R1 rdata holds without read", bus_rdata, 32'h0);
   endtask

   task automatic t_ignored_writes;
      bus_write(6'd1, 32'hFFFF_FFFF);
      bus_write(6'd3, 32'hFFFF_FFFF);
      bus_write(6'd0, 32'hFFFF_FFFF);
      bus_read(6'd1, rv); chk("R2 prog after write", rv, 32'h0);
      bus_read(6'd3, rv); chk("R2 decode after write", rv, 32'h0000_0011);
      bus_read(6'd0, rv); chk("R2 id after write", rv, 32'h4103_4003);
      chk("R2 irq untouched", {31'b0, card_irq}, 32'h0);
   endtask

   task automatic t_write_protect;
      @(negedge clk) wp_in = 1'b1;
      wait_cyc(3);
      bus_read(6'd2, rv); chk("R3 wp high", rv, 32'h1);
      bus_write(6'd2, 32'hFFFF_FFF7);
      bus_read(6'd2, rv); chk("R3 wp after write", rv, 32'h1);
      chk("R3 wp does not raise irq", {31'b0, card_irq}, 32'h0);
      @(negedge clk) wp_in = 1'b0;
      wait_cyc(3);
      bus_read(6'd2, rv); chk("R3 wp low", rv, 32'h0);
   endtask

   task automatic t_sticky_and_clear;
      @(negedge clk) card_in = 1'b1;
      wait_cyc(4);
      chk("R4 irq after insert", {31'b0, card_irq}, 32'h1);
      @(negedge clk) card_in = 1'b0;
      wait_cyc(4);
      chk("R4 irq after removal", {31'b0, card_irq}, 32'h1);
      bus_read(6'd2, rv); chk("R4 status sticky", rv, 32'h8);
      bus_write(6'd2, 32'hFFFF_FFF7);
      chk("R5 zero bit3 no clear", {31'b0, card_irq}, 32'h1);
      bus_write(6'd2, 32'h0000_0008);
      chk("R6 irq falls on ack", {31'b0, card_irq}, 32'h0);
      bus_read(6'd2, rv); chk("R5 status cleared", rv, 32'h0);
   endtask

   task automatic t_level_held;
      @(negedge clk) card_in = 1'b1;
      wait_cyc(4);
      chk("R8 irq set", {31'b0, card_irq}, 32'h1);
      bus_write(6'd2, 32'h8);
      wait_cyc(10);
      chk("R8 held level no reset", {31'b0, card_irq}, 32'h0);
      @(negedge clk) card_in = 1'b0;
      wait_cyc(4);
      @(negedge clk) card_in = 1'b1;
      wait_cyc(4);
      chk("R8 new edge sets", {31'b0, card_irq}, 32'h1);
      @(negedge clk) card_in = 1'b0;
      bus_write(6'd2, 32'h8);
      wait_cyc(4);
   endtask

   task automatic t_collision;
      chk("R7 precondition clear", {31'b0, card_irq}, 32'h0);
      @(negedge clk) card_in = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'd2; bus_wdata = 32'h8;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      chk("R7 set wins over clear", {31'b0, card_irq}, 32'h1);
      wait_cyc(2);
      chk("R7 stays set", {31'b0, card_irq}, 32'h1);
      @(negedge clk) card_in = 1'b0;
      wait_cyc(4);
   endtask

   task automatic t_unmapped;
      bus_read(6'd5, rv);  chk("R9 read word 5", rv, 32'h0);
      bus_read(6'd63, rv); chk("R9 read word 63", rv, 32'h0);
      bus_read(6'd6, rv);  chk("R9 read alias of status", rv, 32'h0);
      bus_write(6'd6, 32'hFFFF_FFFF);
      bus_write(6'd7, 32'h8);
      chk("R9 alias write keeps irq", {31'b0, card_irq}, 32'h1);
      bus_read(6'd2, rv);  chk("R9 status intact", rv, 32'h8);
      bus_write(6'd2, 32'h8);
      chk("R5 final clear", {31'b0, card_irq}, 32'h0);
   endtask

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      t_reset();
      t_constants();
      t_ignored_writes();
      t_write_protect();
      t_sticky_and_clear();
      t_level_held();
      t_collision();
      t_unmapped();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule